// File: doc/BRIEF.md
# Validate-Gated Audio Routing Configuration Bank

This block holds five byte-wide configuration registers for an audio routing front end, written and read over a simple byte-addressed control port. Every write to a register in range lands in a readable shadow copy at once, so a status display always shows the last byte sent. The decoded control fields that steer the audio path change only when the written byte carries its top bit (the validate bit). Without that bit, a byte can be staged and inspected without disturbing the running configuration.

The decoded outputs cover several areas:
- input source selection for the low port group (ports 0 to 7) and the high port group (ports 8 to 11);
- output stream pair selection and the feed of the upper low-group ports;
- eight-channel serial mode and its direction;
- loopback and DAC attenuation;
- sample-rate-converter enables and serial interface formats;
- external clock pin direction, clock output source and audio PLL reference.

A field written with a reserved code keeps its previous active value. The other fields of the same write still take effect.

Top module: `cfg_gate_bank`

## Requirements
- R1: The registers occupy byte addresses 0x800 (register 0) through 0x804 (register 4). A write is taken on a rising clock edge with `wr_en` high.
- R2: Every write to an address in range stores the full byte, bit 7 included, in that register's shadow. `rdata` shows the shadow of the register at `addr` combinationally.
- R3: A write whose bit 7 is 0 changes no decoded control output.
- R4: Register 0 with bit 7 set updates two fields. Bits [1:0] set `src_lo`: 0 SPDIF, 1 optical, 2 serial stereo, 3 tone. Bits [4:3] set `src_hi`: 0 SPDIF, 1 optical, 2 analogue.
- R5: Register 1 with bit 7 set updates five fields. Bits [1:0] set `osel_lo` (output pair 0 to 3). Bit 2 sets `wide_en` (eight-channel mode). Bit 3 sets `wide_out` (0 input, 1 output). Bit 4 sets `osel_hi`. Bit 5 sets `upper_tone`.
- R6: Register 2 with bit 7 set updates two fields. Bit 0 sets `loop_en`. Bits [5:1] give a code n, and `atten_db` = 2·n, from 0 to 62.
- R7: Register 3 with bit 7 set updates the following fields. Bit 0 sets `asrc_in_lo`, bit 1 `asrc_in_hi` and bit 2 `asrc_out`. Bits [4:3] set `fmt_in` and bits [6:5] set `fmt_out`, each coded 0 left-justified, 1 I2S, 2 right-justified. Register 4 with bit 7 set updates the clock fields. Bit 0 sets `xclk_out`. Bits [3:1] set `clkout_src` (0 to 4). Bits [6:4] set `pll_ref`: 0 bus clock, 1 SPDIF, 2 optical, 3 serial master clock, 4 external.
- R8: A reserved code leaves that field's active value unchanged while the other fields of the write update. Reserved codes are `src_hi`=3, `fmt_in`/`fmt_out`=3, and `clkout_src` or `pll_ref` above 4.
- R9: Reset (`rst_n` low) clears every shadow byte and every decoded field to zero.
- R10: Writes outside 0x800–0x804 change no shadow and no output. Reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 12 | Byte address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Shadow byte at `addr`, 0 if out of range |
| src_lo | output | 2 | Low group input source |
| src_hi | output | 2 | High group input source |
| osel_lo | output | 2 | Low group output pair select |
| osel_hi | output | 1 | High group output pair select |
| upper_tone | output | 1 | Ports 4–7 fed from the tone generator |
| wide_en | output | 1 | Eight-channel serial mode |
| wide_out | output | 1 | Eight-channel direction, 1 output |
| loop_en | output | 1 | Loopback enable |
| atten_db | output | 6 | DAC attenuation in dB |
| asrc_in_lo | output | 1 | Low input rate converter on |
| asrc_in_hi | output | 1 | High input rate converter on |
| asrc_out | output | 1 | Output rate converter on |
| fmt_in | output | 2 | Serial input format |
| fmt_out | output | 2 | Serial output format |
| xclk_out | output | 1 | External clock pin drives out |
| clkout_src | output | 3 | External clock output source |
| pll_ref | output | 3 | Audio PLL reference |

## Verification
The assertions check several rules on every cycle:
- the decoded fields hold across any write lacking the validate bit;
- an in-range write lands in its shadow;
- an out-of-range write leaves all shadows untouched;
- the attenuation decode follows a validated write to register 2;
- a reserved PLL reference code leaves the reference unchanged.

Only the bench's scenarios show the following:
- the exact field positions and encodings of each register;
- per-field holding when reserved and legal codes share one byte;
- readback including bit 7 and zero reads outside the window;
- clearing by a reset in mid-run.

// File: rtl/cfg_gate_bank.sv
module cfg_gate_bank #(
  parameter int ADDR_W = 12,
  parameter logic [11:0] BASE = 12'h800,
  parameter int NREG = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [11:0] addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic [1:0]  src_lo,
  output logic [1:0]  src_hi,
  output logic [1:0]  osel_lo,
  output logic        osel_hi,
  output logic        upper_tone,
  output logic        wide_en,
  output logic        wide_out,
  output logic        loop_en,
  output logic [5:0]  atten_db,
  output logic        asrc_in_lo,
  output logic        asrc_in_hi,
  output logic        asrc_out,
  output logic [1:0]  fmt_in,
  output logic [1:0]  fmt_out,
  output logic        xclk_out,
  output logic [2:0]  clkout_src,
  output logic [2:0]  pll_ref
);
  localparam int IW = $clog2(NREG);

  logic [NREG-1:0][7:0] shd;
  logic [NREG-1:0][6:0] act;
  logic [ADDR_W-1:0] off;
  logic [IW-1:0] idx;
  logic hit, wr_hit, apply;
  logic [6:0] cur, nxt;

  assign off    = addr - BASE;
  assign hit    = (addr >= BASE) && (off < ADDR_W'(NREG));
  assign idx    = off[IW-1:0];
  assign wr_hit = wr_en && hit;
  assign apply  = wr_hit && wdata[7];
  assign rdata  = hit ? shd[idx] : 8'h00;
  assign cur    = hit ? act[idx] : 7'h00;

  always_comb begin
    nxt = wdata[6:0];
    case (idx)
      IW'(0): if (wdata[4:3] == 2'd3) nxt[4:3] = cur[4:3];
      IW'(3): begin
        if (wdata[4:3] == 2'd3) nxt[4:3] = cur[4:3];
        if (wdata[6:5] == 2'd3) nxt[6:5] = cur[6:5];
      end
      IW'(4): begin
        if (wdata[3:1] > 3'd4) nxt[3:1] = cur[3:1];
        if (wdata[6:4] > 3'd4) nxt[6:4] = cur[6:4];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd <= '0;
      act <= '0;
    end else begin
      if (wr_hit) shd[idx] <= wdata;
      if (apply)  act[idx] <= nxt;
    end
  end

  assign src_lo     = act[0][1:0];
  assign src_hi     = act[0][4:3];
  assign osel_lo    = act[1][1:0];
  assign wide_en    = act[1][2];
  assign wide_out   = act[1][3];
  assign osel_hi    = act[1][4];
  assign upper_tone = act[1][5];
  assign loop_en    = act[2][0];
  assign atten_db   = {act[2][5:1], 1'b0};
  assign asrc_in_lo = act[3][0];
  assign asrc_in_hi = act[3][1];
  assign asrc_out   = act[3][2];
  assign fmt_in     = act[3][4:3];
  assign fmt_out    = act[3][6:5];
  assign xclk_out   = act[4][0];
  assign clkout_src = act[4][3:1];
  assign pll_ref    = act[4][6:4];

  logic unused_bits;
  assign unused_bits = ^{act[0][2], act[0][6:5], act[1][6], act[2][6], off[ADDR_W-1:IW]};

  logic [41:0] outs;
  assign outs = {src_lo, src_hi, osel_lo, osel_hi, upper_tone, wide_en, wide_out, loop_en,
                 atten_db, asrc_in_lo, asrc_in_hi, asrc_out, fmt_in, fmt_out, xclk_out,
                 clkout_src, pll_ref, 7'd0, 3'd0};

  AST_NOVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit && wdata[7]) |=> $stable(outs)) else $error("hold"); // R3
  AST_SHADOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit) |=> shd[$past(idx)] == $past(wdata)) else $error("shadow"); // R2
  AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> $stable(shd)) else $error("outside"); // R10
  AST_ATTEN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == BASE + 12'd2 && wdata[7]) |=> atten_db == {$past(wdata[5:1]), 1'b0})
    else $error("atten"); // R6
  AST_PLL_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == BASE + 12'd4 && wdata[7] && wdata[6:4] > 3'd4) |=> $stable(pll_ref))
    else $error("pll"); // R8
endmodule

// File: tb/tb_cfg_gate_bank.sv
module tb_cfg_gate_bank;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [11:0] addr = 12'h000;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [1:0] src_lo, src_hi, osel_lo, fmt_in, fmt_out;
  logic osel_hi, upper_tone, wide_en, wide_out, loop_en, asrc_in_lo, asrc_in_hi, asrc_out, xclk_out;
  logic [5:0] atten_db;
  logic [2:0] clkout_src, pll_ref;

  always #4 clk = ~clk;

  cfg_gate_bank dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src_lo(src_lo), .src_hi(src_hi), .osel_lo(osel_lo), .osel_hi(osel_hi),
    .upper_tone(upper_tone), .wide_en(wide_en), .wide_out(wide_out), .loop_en(loop_en),
    .atten_db(atten_db), .asrc_in_lo(asrc_in_lo), .asrc_in_hi(asrc_in_hi), .asrc_out(asrc_out),
    .fmt_in(fmt_in), .fmt_out(fmt_out), .xclk_out(xclk_out), .clkout_src(clkout_src),
    .pll_ref(pll_ref));

  typedef struct { string req; string fld; int expv; } item_t;
  item_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic int get(string f);
    case (f)
      "rdata": return rdata;          "src_lo": return src_lo;
      "src_hi": return src_hi;        "osel_lo": return osel_lo;
      "osel_hi": return osel_hi;      "upper_tone": return upper_tone;
      "wide_en": return wide_en;      "wide_out": return wide_out;
      "loop_en": return loop_en;      "atten_db": return atten_db;
      "asrc_in_lo": return asrc_in_lo; "asrc_in_hi": return asrc_in_hi;
      "asrc_out": return asrc_out;    "fmt_in": return fmt_in;
      "fmt_out": return fmt_out;      "xclk_out": return xclk_out;
      "clkout_src": return clkout_src; "pll_ref": return pll_ref;
      default: return -1;
    endcase
  endfunction

  task automatic expect_v(string req, string f, int v);
    item_t it;
    it.req = req; it.fld = f; it.expv = v;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      int a;
      it = q.pop_front();
      a = get(it.fld);
      n_chk++;
      if (a != it.expv) begin
        n_bad++;
        $display("FAIL %s %s actual=%0d expected=%0d", it.req, it.fld, a, it.expv);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic settle_read(input logic [11:0] a);
    @(posedge clk); #2;
    addr = a;
  endtask

  task automatic drain;
    @(negedge clk); #1;
  endtask

  task automatic all_zero(string req);
    expect_v(req, "src_lo", 0); expect_v(req, "src_hi", 0); expect_v(req, "osel_lo", 0);
    expect_v(req, "wide_en", 0); expect_v(req, "loop_en", 0); expect_v(req, "atten_db", 0);
    expect_v(req, "asrc_out", 0); expect_v(req, "fmt_in", 0); expect_v(req, "pll_ref", 0);
    expect_v(req, "clkout_src", 0); expect_v(req, "xclk_out", 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R9 reset state
    settle_read(12'h800); all_zero("R9"); expect_v("R9", "rdata", 0); drain();
    // R1 R4 validated write to register 0
    wr(12'h800, 8'h8B);
    expect_v("R4", "src_lo", 3); expect_v("R4", "src_hi", 1); expect_v("R1", "rdata", 8'h8B); drain();
    // R3 staged write, R2 readback
    wr(12'h802, 8'h2A);
    expect_v("R3", "loop_en", 0); expect_v("R3", "atten_db", 0); drain();
    settle_read(12'h802); expect_v("R2", "rdata", 8'h2A); drain();
    // R6 loopback and attenuation
    wr(12'h802, 8'hAB);
    expect_v("R6", "loop_en", 1); expect_v("R6", "atten_db", 42); drain();
    wr(12'h802, 8'hBF);
    expect_v("R6", "atten_db", 62); expect_v("R6", "loop_en", 1); drain();
    // R8 reserved high-group source held, low group updates
    wr(12'h800, 8'h9A);
    expect_v("R8", "src_hi", 1); expect_v("R8", "src_lo", 2); expect_v("R2", "rdata", 8'h9A); drain();
    // R7 register 4
    wr(12'h804, 8'hC9);
    expect_v("R7", "pll_ref", 4); expect_v("R7", "clkout_src", 4); expect_v("R7", "xclk_out", 1); drain();
    // R8 reserved PLL reference
    wr(12'h804, 8'hF5);
    expect_v("R8", "pll_ref", 4); expect_v("R8", "clkout_src", 2); expect_v("R2", "rdata", 8'hF5); drain();
    // R5 register 1
    wr(12'h801, 8'h8D);
    expect_v("R5", "osel_lo", 1); expect_v("R5", "wide_en", 1); expect_v("R5", "wide_out", 1);
    expect_v("R5", "osel_hi", 0); expect_v("R5", "upper_tone", 0); drain();
    wr(12'h801, 8'hB2);
    expect_v("R5", "osel_lo", 2); expect_v("R5", "osel_hi", 1); expect_v("R5", "upper_tone", 1);
    expect_v("R5", "wide_en", 0); drain();
    // R7 R8 register 3
    wr(12'h803, 8'hF7);
    expect_v("R7", "asrc_in_lo", 1); expect_v("R7", "asrc_in_hi", 1); expect_v("R7", "asrc_out", 1);
    expect_v("R7", "fmt_in", 2); expect_v("R8", "fmt_out", 0); drain();
    wr(12'h803, 8'hA9);
    expect_v("R7", "fmt_out", 1); expect_v("R7", "fmt_in", 1); expect_v("R7", "asrc_in_hi", 0); drain();
    // R3 staged write to register 4 leaves clocks alone
    wr(12'h804, 8'h00);
    expect_v("R3", "pll_ref", 4); expect_v("R3", "xclk_out", 1); expect_v("R2", "rdata", 0); drain();
    // R10 out of range
    wr(12'h805, 8'hFF);
    expect_v("R10", "rdata", 0); expect_v("R10", "src_lo", 2); expect_v("R10", "loop_en", 1); drain();
    wr(12'h7FF, 8'hFF);
    expect_v("R10", "rdata", 0); expect_v("R10", "pll_ref", 4); drain();
    settle_read(12'h800); expect_v("R10", "rdata", 8'h9A); drain();
    // R9 reset in mid-run
    @(posedge clk); #2 rst_n = 1'b0;
    @(posedge clk); #2 rst_n = 1'b1; addr = 12'h804;
    all_zero("R9"); expect_v("R9", "rdata", 0); drain();
    repeat (2) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule